// File: doc/BRIEF.md
# Hardwired Instruction Cycle Controller

This block is the hardwired control unit and register set of a small single-bus accumulator machine. It holds a program counter, a memory address register, a memory buffer register, an instruction register, an accumulator, and the ALU operand latch and result latch. A two-bit cycle code selects one of four phases. Each phase is a fixed list of register transfers, and each transfer takes exactly one clock. The phases are FETCH (00), INDIRECT (01), EXECUTE (10) and INTERRUPT (11). A step counter from 1 to 5 marks the current step within a phase.

Instructions are 16-bit words. Bit 15 is the indirect flag, bits 14:12 are the operation, and bits 11:0 are the address. The operations are add to accumulator (000), load accumulator (001), store accumulator (010), jump (011) and branch-and-save-return (100). The codes 101 to 111 act as a one-step no-operation. The memory port is single-ported. A read returns data in the same cycle as the read strobe, and a write takes effect at the clock edge that ends the write step. An interrupt enable flag is set by a one-clock pulse on `ie_set`. An interrupt is entered only at the end of EXECUTE.

State transitions are as follows. FETCH t3 goes to INDIRECT t1 when the fetched word has bit 15 set, and to EXECUTE t1 otherwise. INDIRECT t3 goes to EXECUTE t1. The last EXECUTE step goes to INTERRUPT t1 when `irq` and the enable are both high, and to FETCH t1 otherwise. INTERRUPT t3 goes to FETCH t1. Every other step moves to the next step of the same phase.

Top module: `cyc_ctrl`

## Requirements
- R1: A synchronous reset leaves the cycle code at 00, the step at 1, the program counter at 0, the accumulator at 0 and the interrupt enable cleared.
- R2: FETCH lasts three clocks. The read strobe is high in t2. The program counter shows the incremented value from t3 onwards.
- R3: After FETCH, the next phase is INDIRECT if bit 15 of the fetched word is 1, and EXECUTE otherwise. INDIRECT lasts three clocks, reads memory in t2, and replaces bits 11:0 of the instruction with bits 11:0 of the word read.
- R4: Add (000) executes in five clocks and reads memory in t2. The accumulator takes the 16-bit wrapped sum from the cycle after t5. The accumulator changes only at the end of an EXECUTE step.
- R5: Load (001) executes in three clocks and loads the accumulator from memory. Store (010) executes in two clocks and writes the accumulator to the operand address in t2. The read and write strobes are never both high.
- R6: Jump (011) executes in one clock and loads the program counter from the address field. Operation codes 101 to 111 execute in one clock and change no register.
- R7: Branch-and-save-return (100) executes in three clocks. In t2 it writes the return address (the incremented program counter, zero-extended) to the operand address. It then leaves the program counter at the operand address plus one.
- R8: The block enters INTERRUPT only from the last EXECUTE step with `irq` and the enable both high. INTERRUPT lasts three clocks, writes the program counter to address 0 in t3, and sets the program counter to 1.
- R9: A pulse on `ie_set` sets the interrupt enable. The end of INTERRUPT clears it, so a request that stays high does not cause a second entry until the enable is set again.
- R10: `cyc_code` shows the phase as FETCH 00, INDIRECT 01, EXECUTE 10 and INTERRUPT 11. `cyc_step` shows the step number, starting at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_wdata | output | 16 | Memory write data (memory buffer register) |
| mem_rdata | input | 16 | Memory read data, valid in the cycle of the read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, write taken at the end of the cycle |
| irq | input | 1 | Interrupt request, level |
| ie_set | input | 1 | Sets the interrupt enable |
| cyc_code | output | 2 | Current phase code |
| cyc_step | output | 3 | Current step within the phase |
| pc_out | output | 12 | Program counter |
| ac_out | output | 16 | Accumulator |

## Verification
Strobes and the write address and data are combinational from the current step, so they are due in the same cycle as that step. A register loaded in step tN appears one cycle later. The program counter shows its increment in FETCH t3, the accumulator shows the sum in the cycle after EXECUTE t5, and the vector 1 appears in INTERRUPT t3. The bench expands each instruction into one expected record per step and compares that record at the falling edge after each rising edge. Results therefore line up with the step that produced them, and there is no latency guessing. Final memory contents are also checked after each program, which confirms the writes from store, branch-and-save-return and the interrupt.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_INDIR = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_LDA = 3'b001,
        OP_STA = 3'b010,
        OP_JMP = 3'b011,
        OP_BSA = 3'b100
    } op_e;

    localparam int STEP_W = 3;

endpackage

// File: rtl/cyc_seq.sv
module cyc_seq
    import cyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_ind,
    input  op_e               op,
    input  logic              irq,
    input  logic              ie_set,
    output phase_e            phase,
    output logic [STEP_W-1:0] step,
    output logic              ie
);

    phase_e            phase_nx;
    logic [STEP_W-1:0] step_nx;
    logic [STEP_W-1:0] exec_len;

    always_comb begin
        case (op)
            OP_ADD:  exec_len = STEP_W'(5);
            OP_LDA:  exec_len = STEP_W'(3);
            OP_STA:  exec_len = STEP_W'(2);
            OP_BSA:  exec_len = STEP_W'(3);
            default: exec_len = STEP_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
            step  <= STEP_W'(1);
        end else begin
            phase <= phase_nx;
            step  <= step_nx;
        end
    end

    always_comb begin
        phase_nx = phase;
        step_nx  = step + STEP_W'(1);
        unique case (phase)
            PH_FETCH: begin
                if (step == STEP_W'(3)) begin
                    phase_nx = fetch_ind ? PH_INDIR : PH_EXEC;
                    step_nx  = STEP_W'(1);
                end
            end
            PH_INDIR: begin
                if (step == STEP_W'(3)) begin
                    phase_nx = PH_EXEC;
                    step_nx  = STEP_W'(1);
                end
            end
            PH_EXEC: begin
                if (step == exec_len) begin
                    phase_nx = (irq && ie) ? PH_INTR : PH_FETCH;
                    step_nx  = STEP_W'(1);
                end
            end
            PH_INTR: begin
                if (step == STEP_W'(3)) begin
                    phase_nx = PH_FETCH;
                    step_nx  = STEP_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie <= 1'b0;
        end else if (phase == PH_INTR && step == STEP_W'(3)) begin
            ie <= 1'b0;
        end else if (ie_set) begin
            ie <= 1'b1;
        end
    end

endmodule

// File: rtl/cyc_dp.sv
module cyc_dp
    import cyc_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [STEP_W-1:0] step,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] ac,
    output op_e               op,
    output logic              fetch_ind
);

    localparam int IND_BIT = WORD_W - 1;
    localparam int OP_HI   = WORD_W - 2;
    localparam int PAD_W   = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mbr;
    logic [WORD_W-1:0] ir;
    logic [WORD_W-1:0] y_q;
    logic [WORD_W-1:0] z_q;
    logic [ADDR_W-1:0] ir_addr;

    assign ir_addr   = ir[ADDR_W-1:0];
    assign op        = op_e'(ir[OP_HI -: 3]);
    assign fetch_ind = mbr[IND_BIT];
    assign mem_addr  = mar;
    assign mem_wdata = mbr;

    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        if (step == STEP_W'(2)) begin
            unique case (phase)
                PH_FETCH: mem_rd = 1'b1;
                PH_INDIR: mem_rd = 1'b1;
                PH_EXEC: begin
                    mem_rd = (op == OP_ADD) || (op == OP_LDA);
                    mem_wr = (op == OP_STA) || (op == OP_BSA);
                end
                PH_INTR: mem_wr = 1'b0;
            endcase
        end else if (step == STEP_W'(3) && phase == PH_INTR) begin
            mem_wr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            ac  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            y_q <= '0;
            z_q <= '0;
        end else begin
            unique case (phase)
                PH_FETCH: begin
                    case (step)
                        STEP_W'(1): mar <= pc;
                        STEP_W'(2): begin
                            mbr <= mem_rdata;
                            pc  <= pc + ADDR_W'(1);
                        end
                        STEP_W'(3): ir <= mbr;
                        default: ;
                    endcase
                end
                PH_INDIR: begin
                    case (step)
                        STEP_W'(1): mar <= ir_addr;
                        STEP_W'(2): mbr <= mem_rdata;
                        STEP_W'(3): ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
                        default: ;
                    endcase
                end
                PH_EXEC: begin
                    case (op)
                        OP_ADD: begin
                            case (step)
                                STEP_W'(1): mar <= ir_addr;
                                STEP_W'(2): mbr <= mem_rdata;
                                STEP_W'(3): y_q <= mbr;
                                STEP_W'(4): z_q <= ac + y_q;
                                STEP_W'(5): ac  <= z_q;
                                default: ;
                            endcase
                        end
                        OP_LDA: begin
                            case (step)
                                STEP_W'(1): mar <= ir_addr;
                                STEP_W'(2): mbr <= mem_rdata;
                                STEP_W'(3): ac  <= mbr;
                                default: ;
                            endcase
                        end
                        OP_STA: begin
                            if (step == STEP_W'(1)) begin
                                mar <= ir_addr;
                                mbr <= ac;
                            end
                        end
                        OP_JMP: pc <= ir_addr;
                        OP_BSA: begin
                            case (step)
                                STEP_W'(1): begin
                                    mar <= ir_addr;
                                    mbr <= {{PAD_W{1'b0}}, pc};
                                end
                                STEP_W'(2): pc <= ir_addr;
                                STEP_W'(3): pc <= pc + ADDR_W'(1);
                                default: ;
                            endcase
                        end
                        default: ;
                    endcase
                end
                PH_INTR: begin
                    case (step)
                        STEP_W'(1): mbr <= {{PAD_W{1'b0}}, pc};
                        STEP_W'(2): begin
                            mar <= ADDR_W'(SAVE_ADDR);
                            pc  <= ADDR_W'(VEC_ADDR);
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/cyc_ctrl.sv
module cyc_ctrl
    import cyc_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              irq,
    input  logic              ie_set,
    output logic [1:0]        cyc_code,
    output logic [STEP_W-1:0] cyc_step,
    output logic [ADDR_W-1:0] pc_out,
    output logic [WORD_W-1:0] ac_out
);

    phase_e            phase;
    logic [STEP_W-1:0] step;
    op_e               op;
    logic              fetch_ind;
    logic              ie_q;

    cyc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .fetch_ind (fetch_ind),
        .op        (op),
        .irq       (irq),
        .ie_set    (ie_set),
        .phase     (phase),
        .step      (step),
        .ie        (ie_q)
    );

    cyc_dp #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .SAVE_ADDR (SAVE_ADDR),
        .VEC_ADDR  (VEC_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .step      (step),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .pc        (pc_out),
        .ac        (ac_out),
        .op        (op),
        .fetch_ind (fetch_ind)
    );

    assign cyc_code = phase;
    assign cyc_step = step;

endmodule

// File: rtl/cyc_ctrl_chk.sv
module cyc_ctrl_chk #(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        phase,
    input logic [2:0]        step,
    input logic [ADDR_W-1:0] pc,
    input logic [WORD_W-1:0] ac,
    input logic              ie,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (phase == 2'b00 && step == 3'd1 && pc == '0 && ac == '0 && !ie)); // R1

    AST_FETCH_PC_INC: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b00 && step == 3'd2) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R2

    AST_INDIR_TO_EXEC: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b01 && step == 3'd3) |=> (phase == 2'b10 && step == 3'd1)); // R3

    AST_AC_ONLY_EXEC: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'b10) |=> $stable(ac)); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R5

    AST_INT_SAVE_ADDR: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b11 && mem_wr) |-> (mem_addr == ADDR_W'(SAVE_ADDR))); // R8

    AST_INT_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b11 && step == 3'd3) |-> (pc == ADDR_W'(VEC_ADDR))); // R8

    AST_INT_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b10 && !ie) |=> (phase != 2'b11)); // R8

    AST_IE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b11 && step == 3'd3) |=> !ie); // R9

    AST_INT_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b11 && step == 3'd3) |=> (phase == 2'b00 && step == 3'd1)); // R10

endmodule

bind cyc_ctrl cyc_ctrl_chk #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase    (cyc_code),
    .step     (cyc_step),
    .pc       (pc_out),
    .ac       (ac_out),
    .ie       (ie_q),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr)
);

// File: tb/cyc_ctrl_tb.sv
module cyc_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rd;
    logic        mem_wr;
    logic        irq = 1'b0;
    logic        ie_set = 1'b0;
    logic [1:0]  cyc_code;
    logic [2:0]  cyc_step;
    logic [11:0] pc_out;
    logic [15:0] ac_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    int intr_cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cyc_ctrl u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .irq(irq), .ie_set(ie_set), .cyc_code(cyc_code), .cyc_step(cyc_step),
        .pc_out(pc_out), .ac_out(ac_out)
    );

    logic [15:0] mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    typedef struct {
        logic [1:0]  ph;
        int          st;
        logic [11:0] pc;
        logic [15:0] ac;
        bit          wr;
        logic [11:0] wa;
        logic [15:0] wd;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] mm [256];
    logic [11:0] m_pc;
    logic [15:0] m_ac;
    logic [15:0] m_ir;
    bit          m_ie;
    bit          m_irq;

    task automatic chk(input bit ok, input string what, input int got, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", what, got, expv, cycles);
        end
    endtask

    task automatic push(input logic [1:0] ph, input int st, input string tag);
        exp_t e;
        e.ph = ph; e.st = st; e.pc = m_pc; e.ac = m_ac;
        e.wr = 0; e.wa = '0; e.wd = '0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic push_wr(input logic [1:0] ph, input int st, input logic [11:0] wa,
                           input logic [15:0] wd, input string tag);
        exp_t e;
        e.ph = ph; e.st = st; e.pc = m_pc; e.ac = m_ac;
        e.wr = 1; e.wa = wa; e.wd = wd; e.tag = tag;
        q.push_back(e);
    endtask

    // Expands one whole instruction (and a following interrupt) into step records
    task automatic gen_instr();
        logic [11:0] a;
        logic [11:0] ret;
        push(2'b00, 1, "R2");
        push(2'b00, 2, "R2");
        m_ir = mm[m_pc[7:0]];
        m_pc = m_pc + 12'd1;
        push(2'b00, 3, "R2");
        if (m_ir[15]) begin
            push(2'b01, 1, "R3");
            push(2'b01, 2, "R3");
            push(2'b01, 3, "R3");
            m_ir[11:0] = mm[m_ir[7:0]][11:0];
        end
        a = m_ir[11:0];
        case (m_ir[14:12])
            3'b000: begin
                for (int s = 1; s <= 5; s++) push(2'b10, s, "R4");
                m_ac = m_ac + mm[a[7:0]];
            end
            3'b001: begin
                for (int s = 1; s <= 3; s++) push(2'b10, s, "R5");
                m_ac = mm[a[7:0]];
            end
            3'b010: begin
                push(2'b10, 1, "R5");
                push_wr(2'b10, 2, a, m_ac, "R5");
                mm[a[7:0]] = m_ac;
            end
            3'b011: begin
                push(2'b10, 1, "R6");
                m_pc = a;
            end
            3'b100: begin
                push(2'b10, 1, "R7");
                push_wr(2'b10, 2, a, {4'b0, m_pc}, "R7");
                mm[a[7:0]] = {4'b0, m_pc};
                m_pc = a;
                push(2'b10, 3, "R7");
                m_pc = a + 12'd1;
            end
            default: push(2'b10, 1, "R6");
        endcase
        if (m_irq && m_ie) begin
            push(2'b11, 1, "R8");
            push(2'b11, 2, "R8");
            ret = m_pc;
            m_pc = 12'd1;
            push_wr(2'b11, 3, 12'd0, {4'b0, ret}, "R8");
            mm[0] = {4'b0, ret};
            m_ie = 0;
        end
    endtask

    task automatic compare_cycle();
        exp_t e;
        if (q.size() == 0) gen_instr();
        e = q.pop_front();
        if (cyc_code == 2'b11) intr_cycles++;
        chk(cyc_code == e.ph, {"R10 phase code ", e.tag}, cyc_code, e.ph);
        chk(cyc_step == 3'(e.st), {"R10 step ", e.tag}, cyc_step, e.st);
        chk(pc_out == e.pc, {"pc ", e.tag}, pc_out, e.pc);
        chk(ac_out == e.ac, {"ac ", e.tag}, ac_out, e.ac);
        chk(mem_wr == e.wr, {"write strobe ", e.tag}, mem_wr, e.wr);
        if (e.wr && mem_wr) begin
            chk(mem_addr == e.wa, {"write address ", e.tag}, mem_addr, e.wa);
            chk(mem_wdata == e.wd, {"write data ", e.tag}, mem_wdata, e.wd);
        end
    endtask

    task automatic load(input int adr, input logic [15:0] w);
        mem[adr] = w;
        mm[adr]  = w;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'h0;
            mm[i]  = 16'h0;
        end
    endtask

    task automatic run(input bit arm, input bit req, input int ncyc);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is held
        chk(cyc_code == 2'b00 && cyc_step == 3'd1, "R1 reset phase/step", {cyc_code, cyc_step}, 5'b00001);
        chk(pc_out == 12'd0, "R1 reset pc", pc_out, 0);
        chk(ac_out == 16'd0, "R1 reset ac", ac_out, 0);
        q.delete();
        m_pc = '0; m_ac = '0; m_ir = '0; m_ie = arm; m_irq = req;
        intr_cycles = 0;
        irq = req;
        rst = 1'b0;
        ie_set = arm;
        compare_cycle();
        for (int c = 1; c < ncyc; c++) begin
            @(negedge clk);
            ie_set = 1'b0;
            compare_cycle();
        end
    endtask

    initial begin
        // Program 1: no interrupts; wrap-around add, indirect, store, BSA, no-op
        clear_mem();
        load(8'h00, 16'h1020);   // LDA 20
        load(8'h01, 16'h0021);   // ADD 21
        load(8'h02, 16'h8022);   // ADD @22
        load(8'h03, 16'h2024);   // STA 24
        load(8'h04, 16'h4030);   // BSA 30
        load(8'h31, 16'h9025);   // LDA @25
        load(8'h32, 16'h3040);   // JMP 40
        load(8'h40, 16'h7000);   // unused code, no-op
        load(8'h41, 16'h3041);   // JMP 41
        load(8'h20, 16'hFFF0);
        load(8'h21, 16'h0015);
        load(8'h22, 16'h0023);
        load(8'h23, 16'h0005);
        load(8'h25, 16'h0024);
        run(1'b0, 1'b0, 100);
        chk(mem[8'h24] == 16'h000A, "R5 stored sum", mem[8'h24], 16'h000A);
        chk(mem[8'h30] == 16'h0005, "R7 saved return address", mem[8'h30], 16'h0005);
        chk(ac_out == 16'h000A, "R4 wrapped sum via indirect load", ac_out, 16'h000A);
        chk(intr_cycles == 0, "R8 no interrupt when disabled", intr_cycles, 0);

        // Program 2: request held high, enable pulsed once
        clear_mem();
        load(8'h00, 16'h3010);   // JMP 10
        load(8'h01, 16'h1020);   // handler: LDA 20
        load(8'h02, 16'h3002);   // JMP 2
        load(8'h10, 16'h1021);   // not reached
        load(8'h20, 16'h1234);
        run(1'b1, 1'b1, 60);
        chk(mem[8'h00] == 16'h0010, "R8 saved pc at address 0", mem[8'h00], 16'h0010);
        chk(intr_cycles == 3, "R9 single interrupt entry", intr_cycles, 3);
        chk(ac_out == 16'h1234, "R8 handler ran", ac_out, 16'h1234);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule